// File: doc/BRIEF.md
# Volatile/Nonvolatile Shadow Transfer Controller

This block owns a byte-wide volatile working array and a second array that stands for its nonvolatile shadow copy. Both are built from on-chip registers. In normal operation the volatile array is reached through a small request/response port. Two transfer kinds can take the array away from that port. A store empties the shadow and then programs it from the volatile array. A recall zeroes the volatile array and then loads it from the shadow.

Each transfer phase lasts a fixed number of clock cycles, set by parameters. Store phases are long and recall phases short. A rising `supply_ok` starts a recall on its own. A falling `supply_ok` cancels a store that is running. It never cancels a recall. A cancelled store leaves the shadow zeroed and flagged invalid. Completed stores are counted in a saturating counter, and every completed transfer gives a one-cycle `done` pulse.

The access port is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low during a transfer and in the cycle in which a transfer is being started. A requester that sees `req_ready` low must hold its request, or withdraw it. The read response (`rsp_valid`, `rsp_data`) comes exactly one cycle after a read is taken. It cannot be back-pressured.

Top module: `nvshadow_ctrl`

## Requirements
- R1: After reset, with `supply_ok` low, `busy`, `done` and `shadow_invalid` are 0, `store_count` is 0 and `req_ready` is 1. The shadow array resets to all zeros.
- R2: Handshake rules:
  - A write is taken when `req_valid`, `req_ready` and `req_write` are all 1.
  - A read is taken when `req_valid` and `req_ready` are 1 and `req_write` is 0.
  - A taken read gives `rsp_valid` for one cycle on the next cycle, with the byte at `req_addr` on `rsp_data`.
- R3: While `busy` is 1, `req_ready` and `rsp_valid` stay 0 and port writes leave the volatile array unchanged.
- R4: A store runs in two phases. The erase phase lasts `ERASE_CYC` cycles and zeroes the shadow. The program phase lasts `PROG_CYC` cycles and then copies every volatile byte into the shadow. `busy` stays high for `ERASE_CYC+PROG_CYC` cycles, and `done` pulses in the first idle cycle after.
- R5: A recall runs in two phases. The clear phase lasts `CLEAR_CYC` cycles and zeroes the volatile array. The copy phase lasts `COPY_CYC` cycles and then loads the shadow into it. A recall never changes the shadow or `store_count`, and it may be repeated any number of times.
- R6: A rising edge of `supply_ok` while idle starts a recall. That edge takes priority over both request inputs in the same cycle.
- R7: A store request made while `supply_ok` is low is refused, so `busy` stays 0.
- R8: If `supply_ok` falls during a store, the controller returns to idle on the next cycle. No `done` pulse is given, the count does not increase, and the shadow stays zeroed.
- R9: A fall of `supply_ok` during a recall does not stop it. The recall still completes and gives `done`.
- R10: A store or recall request made while `busy` is 1 is dropped and not queued.
- R11: `store_count` counts completed stores and saturates at 2^`CNT_W`-1.
- R12: `shadow_invalid` rises when a store erase begins. It falls only when a store completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok | input | 1 | Supply-good level, synchronous to clk |
| store_req | input | 1 | Store request pulse |
| recall_req | input | 1 | Recall request pulse |
| req_valid | input | 1 | Port request valid |
| req_ready | output | 1 | Port request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | DW | Read data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after a completed transfer |
| shadow_invalid | output | 1 | Shadow holds no completed store |
| store_count | output | CNT_W | Saturating count of completed stores |

## Verification
The assertions take `supply_ok` and the two request pulses to be synchronous to `clk`. They also take a port request to stay stable while `req_ready` is low. No input may take an unknown value once reset has been released. The stimulus changes every input only on the falling clock edge. It keeps a port request asserted until `req_ready` is seen high, and it withdraws the request on the same falling edge at which `busy` drops. In this way no write slips in at the end of a transfer unless the bench intends it.

// File: rtl/nvs_pkg.sv
`timescale 1ns/1ps
package nvs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ERASE,
    PH_PROG,
    PH_CLEAR,
    PH_COPY
  } phase_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/nvs_phase_timer.sv
`timescale 1ns/1ps
module nvs_phase_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] len,
  input  logic          clr,
  output logic          expire
);
  logic [TW-1:0] cnt;
  logic          active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (start) begin
      cnt    <= len - 1'b1;
      active <= 1'b1;
    end else if (clr) begin
      active <= 1'b0;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assign expire = active && (cnt == '0);
endmodule

// File: rtl/nvs_work_array.sv
`timescale 1ns/1ps
module nvs_work_array #(
  parameter int DEPTH = 2048,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          clear,
  input  logic          load,
  input  logic [DW-1:0] load_img [DEPTH],
  output logic [DW-1:0] img [DEPTH],
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (clear) begin
      for (int i = 0; i < DEPTH; i++) img[i] <= '0;
    end else if (load) begin
      for (int i = 0; i < DEPTH; i++) img[i] <= load_img[i];
    end else if (wr_en) begin
      img[addr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= img[addr];
    end
  end

  assert_no_access_in_transfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clear || load) |-> !(wr_en || rd_en));
endmodule

// File: rtl/nvs_shadow_array.sv
`timescale 1ns/1ps
module nvs_shadow_array #(
  parameter int DEPTH = 2048,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          erase,
  input  logic          program_en,
  input  logic [DW-1:0] src_img [DEPTH],
  output logic [DW-1:0] img [DEPTH]
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) img[i] <= '0;
    end else if (erase) begin
      for (int i = 0; i < DEPTH; i++) img[i] <= '0;
    end else if (program_en) begin
      for (int i = 0; i < DEPTH; i++) img[i] <= src_img[i];
    end
  end

  assert_erase_program_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(erase && program_en));
endmodule

// File: rtl/nvshadow_ctrl.sv
`timescale 1ns/1ps
module nvshadow_ctrl
  import nvs_pkg::*;
#(
  parameter int DEPTH     = 2048,
  parameter int DW        = 8,
  parameter int ERASE_CYC = 1000000,
  parameter int PROG_CYC  = 1000000,
  parameter int CLEAR_CYC = 2000,
  parameter int COPY_CYC  = 2000,
  parameter int CNT_W     = 17,
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic             store_req,
  input  logic             recall_req,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_data,
  output logic             busy,
  output logic             done,
  output logic             shadow_invalid,
  output logic [CNT_W-1:0] store_count
);
  localparam int MAX_LEN = max_of(max_of(ERASE_CYC, PROG_CYC), max_of(CLEAR_CYC, COPY_CYC));
  localparam int TW      = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  phase_e        ph, ph_nx;
  logic          supply_q, supply_rise;
  logic          start_recall, start_store, abort_store;
  logic          tmr_start, tmr_expire;
  logic [TW-1:0] tmr_len;
  logic          sh_erase, sh_prog, wk_clear, wk_load, wr_en, rd_en;
  logic [DW-1:0] work_img   [DEPTH];
  logic [DW-1:0] shadow_img [DEPTH];

  assign supply_rise  = supply_ok && !supply_q;
  assign start_recall = (ph == PH_IDLE) && (supply_rise || recall_req);
  assign start_store  = (ph == PH_IDLE) && !start_recall && store_req && supply_ok;
  assign abort_store  = ((ph == PH_ERASE) || (ph == PH_PROG)) && !supply_ok;

  always_comb begin
    ph_nx     = ph;
    tmr_start = 1'b0;
    tmr_len   = '0;
    unique case (ph)
      PH_IDLE: begin
        if (start_recall) begin
          ph_nx = PH_CLEAR; tmr_start = 1'b1; tmr_len = TW'(CLEAR_CYC);
        end else if (start_store) begin
          ph_nx = PH_ERASE; tmr_start = 1'b1; tmr_len = TW'(ERASE_CYC);
        end
      end
      PH_ERASE: begin
        if (!supply_ok) ph_nx = PH_IDLE;
        else if (tmr_expire) begin
          ph_nx = PH_PROG; tmr_start = 1'b1; tmr_len = TW'(PROG_CYC);
        end
      end
      PH_PROG: begin
        if (!supply_ok || tmr_expire) ph_nx = PH_IDLE;
      end
      PH_CLEAR: begin
        if (tmr_expire) begin
          ph_nx = PH_COPY; tmr_start = 1'b1; tmr_len = TW'(COPY_CYC);
        end
      end
      PH_COPY: begin
        if (tmr_expire) ph_nx = PH_IDLE;
      end
      default: ph_nx = PH_IDLE;
    endcase
  end

  assign sh_erase  = (ph == PH_ERASE);
  assign sh_prog   = (ph == PH_PROG) && tmr_expire && supply_ok;
  assign wk_clear  = (ph == PH_CLEAR);
  assign wk_load   = (ph == PH_COPY) && tmr_expire;
  assign req_ready = (ph == PH_IDLE) && !start_recall && !start_store;
  assign wr_en     = req_valid && req_ready && req_write;
  assign rd_en     = req_valid && req_ready && !req_write;
  assign busy      = (ph != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph             <= PH_IDLE;
      supply_q       <= 1'b0;
      done           <= 1'b0;
      shadow_invalid <= 1'b0;
      store_count    <= '0;
    end else begin
      ph       <= ph_nx;
      supply_q <= supply_ok;
      done     <= sh_prog || wk_load;
      if (sh_erase)     shadow_invalid <= 1'b1;
      else if (sh_prog) shadow_invalid <= 1'b0;
      if (sh_prog && (store_count != CNT_MAX)) store_count <= store_count + 1'b1;
    end
  end

  nvs_phase_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .len(tmr_len),
    .clr(abort_store), .expire(tmr_expire)
  );

  nvs_work_array #(.DEPTH(DEPTH), .DW(DW)) u_work (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(req_addr),
    .wdata(req_wdata), .clear(wk_clear), .load(wk_load), .load_img(shadow_img),
    .img(work_img), .rd_valid(rsp_valid), .rd_data(rsp_data)
  );

  nvs_shadow_array #(.DEPTH(DEPTH), .DW(DW)) u_shadow (
    .clk(clk), .rst_n(rst_n), .erase(sh_erase), .program_en(sh_prog),
    .src_img(work_img), .img(shadow_img)
  );

  assert_port_quiet_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rsp_valid);
  assert_store_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph == PH_IDLE) && !supply_ok) |=> (ph != PH_ERASE));
  assert_store_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (((ph == PH_ERASE) || (ph == PH_PROG)) && !supply_ok) |=> ((ph == PH_IDLE) && !done));
  assert_recall_keeps_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph == PH_CLEAR) || (ph == PH_COPY)) |=> $stable(store_count));
  assert_auto_recall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph == PH_IDLE) && supply_ok && !supply_q) |=> (ph == PH_CLEAR));
  assert_recall_not_aborted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph == PH_CLEAR) && !tmr_expire) |=> (ph == PH_CLEAR));
  assert_count_saturates_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (store_count == CNT_MAX) |=> (store_count == CNT_MAX));
  assert_invalid_clears_on_store_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shadow_invalid) |-> $past(ph == PH_PROG));
endmodule

// File: tb/nvshadow_ctrl_bench.sv
`timescale 1ns/1ps
module nvshadow_ctrl_bench;
  localparam int DEPTH = 2048;
  localparam int EC = 20, PC = 15, CC = 6, YC = 5, CW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic supply_ok = 0, store_req = 0, recall_req = 0;
  logic req_valid = 0, req_write = 0;
  logic [10:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, busy, done, shadow_invalid;
  logic [7:0] rsp_data;
  logic [CW-1:0] store_count;

  int total = 0, fails = 0;
  byte unsigned model_vol [DEPTH];
  byte unsigned model_sh  [DEPTH];
  int exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  nvshadow_ctrl #(.DEPTH(DEPTH), .DW(8), .ERASE_CYC(EC), .PROG_CYC(PC),
                  .CLEAR_CYC(CC), .COPY_CYC(YC), .CNT_W(CW)) u_nvshadow_ctrl (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .store_req(store_req),
    .recall_req(recall_req), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy), .done(done),
    .shadow_invalid(shadow_invalid), .store_count(store_count)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) check("R2 unexpected response", 1, 0);
      else check(tag_q.pop_front(), int'(rsp_data), exp_q.pop_front());
    end
  end

  // driver: one port op, starts and ends on a falling edge
  task automatic port_op(input bit wr, input int a, input int d, input string req);
    req_valid = 1; req_write = wr; req_addr = 11'(a); req_wdata = 8'(d);
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    if (wr) model_vol[a] = 8'(d);
    else begin exp_q.push_back(int'(model_vol[a])); tag_q.push_back(req); end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic drain(input string req);
    repeat (2) @(negedge clk);
    check({req, " scoreboard drained"}, exp_q.size(), 0);
  endtask

  task automatic pulse(input bit is_store);
    if (is_store) store_req = 1; else recall_req = 1;
    @(negedge clk);
    store_req = 0; recall_req = 0;
  endtask

  // counts falling edges with busy high; reports port violations; exits on first idle edge
  task automatic wait_idle(output int n, output int viol, output bit d);
    n = 0; viol = 0;
    while (busy && n < 5000) begin
      if (req_ready || rsp_valid) viol++;
      n++;
      @(negedge clk);
    end
    req_valid = 0;
    d = done;
  endtask

  task automatic model_store(); foreach (model_sh[i]) model_sh[i] = model_vol[i]; endtask
  task automatic model_recall(); foreach (model_vol[i]) model_vol[i] = model_sh[i]; endtask

  initial begin
    #750000;
    check("watchdog expired", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int n, v;
    bit d;
    foreach (model_vol[i]) begin model_vol[i] = 0; model_sh[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 count", store_count, 0);
    check("R1 invalid", shadow_invalid, 0);
    check("R1 ready", req_ready, 1);

    // R6: supply rise starts recall, beats a same-cycle store request (R10 style drop)
    supply_ok = 1; store_req = 1;
    @(negedge clk); store_req = 0;
    wait_idle(n, v, d);
    check("R6 recall length", n, CC + YC);
    check("R6 done", d, 1);
    check("R6 store not started", store_count, 0);
    model_recall();
    port_op(0, 5, 0, "R6 cleared byte");

    // R2 writes and reads at edges of the address range
    port_op(1, 0, 8'hA5, "R2"); port_op(1, 2047, 8'h3C, "R2");
    port_op(1, 100, 8'h77, "R2"); port_op(1, 1365, 8'h5A, "R2");
    port_op(0, 0, 0, "R2 read 0"); port_op(0, 2047, 0, "R2 read top");
    port_op(0, 1365, 0, "R2 read mid");
    drain("R2");

    // R4 store, with blocked port write (R3) and a dropped recall request (R10)
    pulse(1);
    recall_req = 1; req_valid = 1; req_write = 1; req_addr = 11'd100; req_wdata = 8'hEE;
    @(negedge clk); recall_req = 0;
    wait_idle(n, v, d);
    check("R4 store length", n + 1, EC + PC);
    check("R4 done", d, 1);
    check("R3 port quiet while busy", v, 0);
    check("R4 count", store_count, 1);
    check("R12 invalid cleared", shadow_invalid, 0);
    model_store();
    repeat (3) @(negedge clk);
    check("R10 no queued recall", busy, 0);
    check("R4 done is one pulse", done, 0);
    port_op(0, 100, 0, "R3 blocked write");

    // R5 recall restores, repeatable
    port_op(1, 0, 8'h11, "R5"); port_op(1, 2047, 8'h22, "R5");
    for (int k = 0; k < 2; k++) begin
      pulse(0);
      wait_idle(n, v, d);
      check("R5 recall length", n, CC + YC);
      model_recall();
      port_op(0, 0, 0, "R5 restored 0"); port_op(0, 2047, 0, "R5 restored top");
      port_op(0, 1365, 0, "R5 restored mid");
    end
    check("R5 count unchanged", store_count, 1);
    drain("R5");

    // R9 recall survives a supply drop
    pulse(0);
    @(negedge clk); supply_ok = 0;
    wait_idle(n, v, d);
    check("R9 recall completes", n + 1, CC + YC);
    check("R9 done", d, 1);
    model_recall();

    // R7 store refused with supply low
    pulse(1);
    check("R7 not busy", busy, 0);
    repeat (2) @(negedge clk);
    check("R7 count", store_count, 1);

    // R6 again, then R8 abort
    supply_ok = 1;
    @(negedge clk);
    wait_idle(n, v, d);
    check("R6 second auto recall", d, 1);
    model_recall();
    port_op(1, 0, 8'h99, "R8");
    pulse(1);
    repeat (9) @(negedge clk);
    supply_ok = 0;
    @(negedge clk);
    check("R8 idle after drop", busy, 0);
    check("R8 no done", done, 0);
    check("R8 count", store_count, 1);
    check("R12 invalid after abort", shadow_invalid, 1);
    foreach (model_sh[i]) model_sh[i] = 0;
    supply_ok = 1;
    @(negedge clk);
    wait_idle(n, v, d);
    model_recall();
    port_op(0, 0, 0, "R8 shadow erased 0"); port_op(0, 2047, 0, "R8 shadow erased top");
    drain("R8");
    check("R12 invalid held by recall", shadow_invalid, 1);

    // R11 saturation: counts 2, 3, 3
    for (int k = 0; k < 3; k++) begin
      port_op(1, 7, k + 1, "R11");
      pulse(1);
      wait_idle(n, v, d);
      model_store();
      check("R11 count", store_count, (k < 2) ? k + 2 : 3);
    end
    check("R12 invalid cleared again", shadow_invalid, 0);
    pulse(0);
    wait_idle(n, v, d);
    model_recall();
    port_op(0, 7, 0, "R11 last store kept");
    drain("R11");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule